// File: doc/BRIEF.md
# Channel Completion Reporter

This block sits beside a sixteen-channel descriptor-driven DMA engine and handles everything that happens after a channel's command list is launched. Software starts a channel by writing a list pointer. The engine then works the list. This block records the outcome of each list in a small per-channel result queue, which software reads over a 32-bit register bus. The outcome can be normal completion, a fault, or an abort requested by software.

Two things are per channel: whether a result raises the interrupt line, and whether an aborted list leaves a result at all. A bitmask register shows which channels hold unread results. One level-sensitive interrupt output is the OR of that mask, filtered by the per-channel interrupt enables. In this block, single-cycle done and fault pulses stand in for the engine's transfer datapath.

The register window is decoded only when the address selects this instance's environment view. Views are 0x800 bytes apart, chosen by a parameter.

Top module: `dma_cmpl_unit`

## Requirements
- R1: A write to the pointer register of an idle channel (view offset 0x000 + 4*ch) stores the value and makes the channel active. The stored value reads back from that offset. Status bit 0 (view offset 0x200 + 4*ch) reads 1 while the channel is active.
- R2: A done pulse on an active channel ends the list. It queues the result word 0x80000002: bit 31 is valid and bit 1 is list-done. Status bit 1 then reads 1, and bit 0 reads 0.
- R3: A fault pulse on an active channel ends the list and queues 0x80000008 (bit 3 is error). When done and fault arrive in the same cycle, the fault wins.
- R4: A write of any value to the abort register (offset 0x080 + 4*ch) of an active channel ends the list. If config bit 1 (offset 0x300 + 4*ch) is set, it queues 0x80000004 (bit 2 is aborted). If that bit is clear, it queues nothing.
- R5: A pointer write to an active channel has no effect on the stored pointer, and the channel stays active. It queues the error result 0x80000008.
- R6: A read of the result register (offset 0x040 + 4*ch) returns the oldest queued word and removes it. With the queue empty, the read returns 0 and status bit 1 reads 0.
- R7: The summary register (offset 0x380) has bit ch set exactly when channel ch holds at least one unread result.
- R8: The irq output is high exactly when some channel has both an unread result and config bit 0 set.
- R9: Each channel queues up to two results in arrival order. A result that arrives when both entries are full is dropped, and it sets bit 3 on the newer held entry.
- R10: Done or fault pulses and abort writes on an idle channel change nothing.
- R11: Accesses whose address bits above bit 10 differ from the view parameter are ignored. Such reads return 0 and do not pop any result.
- R12: After reset every channel is idle with empty queues and zero config and pointer. The summary register reads 0 and irq is low.
- R13: A bus action on a channel takes precedence over a done or fault pulse on that channel in the same cycle. The pulse is then lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a result read pops on the clock edge |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_rd is high |
| ev_done | input | 16 | Per-channel list-finished pulse from the engine |
| ev_fault | input | 16 | Per-channel list-fault pulse from the engine |
| chan_active | output | 16 | Per-channel list-in-progress flag toward the engine |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume three things about the inputs. Read and write strobes are never high in the same cycle. Each strobe lasts exactly one cycle per access. Engine pulses carry no meaning for a channel that is idle. The stimulus drives every access through single-cycle bus tasks that raise only one strobe, and it applies done and fault pulses on idle channels only where R10 is being tested. The queue-depth and ordering properties rely on a pop happening only when a result read hits an in-view address, which is the only way the bench consumes results.

// File: rtl/dma_cmpl_pkg.sv
package dma_cmpl_pkg;
    localparam int DATA_W = 32;

    localparam logic [DATA_W-1:0] RES_VALID = 32'h8000_0000;
    localparam logic [DATA_W-1:0] RES_ERR   = 32'h0000_0008;
    localparam logic [DATA_W-1:0] RES_ABORT = 32'h0000_0004;
    localparam logic [DATA_W-1:0] RES_DONE  = 32'h0000_0002;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PTR,
        RG_RES,
        RG_ABORT,
        RG_STAT,
        RG_CFG,
        RG_SUM
    } reg_sel_e;

    typedef struct packed {
        logic              active;
        logic [1:0]        cfg;
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] slot0;
        logic [DATA_W-1:0] slot1;
        logic [1:0]        fill;
    } chan_state_t;
endpackage

// File: rtl/dma_cmpl_decode.sv
module dma_cmpl_decode
    import dma_cmpl_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_CH   = 16,
    parameter int VIEW_SEL = 0,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [CH_W-1:0]   chan
);
    localparam int VIEW_W = ADDR_W - 11;

    logic [10:0] off;
    logic [4:0]  blk;
    logic        in_view;

    always_comb begin
        off     = addr[10:0];
        blk     = off[10:6];
        chan    = off[2 +: CH_W];
        in_view = (addr[ADDR_W-1:11] == VIEW_W'(VIEW_SEL));
        sel     = RG_NONE;
        if (in_view) begin
            if (off == 11'h380) begin
                sel = RG_SUM;
            end else if (32'(off[5:2]) < NUM_CH) begin
                case (blk)
                    5'd0:    sel = RG_PTR;
                    5'd1:    sel = RG_RES;
                    5'd2:    sel = RG_ABORT;
                    5'd8:    sel = RG_STAT;
                    5'd12:   sel = RG_CFG;
                    default: sel = RG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_cmpl_chan.sv
module dma_cmpl_chan
    import dma_cmpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ptr,
    input  logic              wr_abort,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    input  logic              ev_done,
    input  logic              ev_fault,
    output logic              active,
    output logic [DATA_W-1:0] ptr,
    output logic [1:0]        cfg,
    output logic [DATA_W-1:0] head,
    output logic              pending
);
    chan_state_t state_d, state_q;
    logic              push;
    logic [DATA_W-1:0] res;
    logic              bus_hit;

    always_comb begin
        state_d = state_q;
        push    = 1'b0;
        res     = '0;
        bus_hit = wr_ptr | wr_abort | wr_cfg | pop;

        if (pop && state_d.fill != 2'd0) begin
            state_d.slot0 = state_d.slot1;
            state_d.slot1 = '0;
            state_d.fill  = state_d.fill - 2'd1;
        end

        if (wr_cfg) begin
            state_d.cfg = wdata[1:0];
        end

        if (wr_ptr) begin
            if (state_q.active) begin
                push = 1'b1;
                res  = RES_VALID | RES_ERR;
            end else begin
                state_d.active = 1'b1;
                state_d.ptr    = wdata;
            end
        end else if (wr_abort) begin
            if (state_q.active) begin
                state_d.active = 1'b0;
                if (state_q.cfg[1]) begin
                    push = 1'b1;
                    res  = RES_VALID | RES_ABORT;
                end
            end
        end else if (!bus_hit && state_q.active && ev_fault) begin
            state_d.active = 1'b0;
            push           = 1'b1;
            res            = RES_VALID | RES_ERR;
        end else if (!bus_hit && state_q.active && ev_done) begin
            state_d.active = 1'b0;
            push           = 1'b1;
            res            = RES_VALID | RES_DONE;
        end

        if (push) begin
            case (state_d.fill)
                2'd0: begin
                    state_d.slot0 = res;
                    state_d.fill  = 2'd1;
                end
                2'd1: begin
                    state_d.slot1 = res;
                    state_d.fill  = 2'd2;
                end
                default: state_d.slot1 = state_d.slot1 | RES_ERR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign active  = state_q.active;
    assign ptr     = state_q.ptr;
    assign cfg     = state_q.cfg;
    assign pending = (state_q.fill != 2'd0);
    assign head    = pending ? state_q.slot0 : '0;

    assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.fill <= 2'd2);

    assert_idle_event_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.active && !wr_ptr && (ev_done || ev_fault)) |=> (state_q.fill <= $past(state_q.fill)) && !state_q.active);

    assert_done_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && ev_done && !ev_fault && !bus_hit && state_q.fill == 2'd0)
        |=> (state_q.fill == 2'd1) && (head == 32'h8000_0002) && !state_q.active);

    assert_busy_ptr_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && wr_ptr) |=> $stable(state_q.ptr) && state_q.active);

    assert_pop_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !state_q.active && !wr_ptr && state_q.fill != 2'd0)
        |=> state_q.fill == $past(state_q.fill) - 2'd1);

    assert_overflow_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && ev_fault && !bus_hit && state_q.fill == 2'd2)
        |=> (state_q.fill == 2'd2) && state_q.slot1[3]);
endmodule

// File: rtl/dma_cmpl_irq.sv
module dma_cmpl_irq #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pending,
    input  logic [NUM_CH-1:0] ien,
    output logic [NUM_CH-1:0] summary,
    output logic              irq
);
    assign summary = pending;
    assign irq     = |(pending & ien);

    assert_irq_needs_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (summary != '0));
endmodule

// File: rtl/dma_cmpl_unit.sv
module dma_cmpl_unit
    import dma_cmpl_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_CH   = 16,
    parameter int VIEW_SEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_fault,
    output logic [NUM_CH-1:0] chan_active,
    output logic              irq
);
    localparam int CH_W = $clog2(NUM_CH);

    reg_sel_e           sel;
    logic [CH_W-1:0]    chan;
    logic [NUM_CH-1:0]  pending;
    logic [NUM_CH-1:0]  ien;
    logic [NUM_CH-1:0]  summary;
    logic [DATA_W-1:0]  ptr_v  [NUM_CH];
    logic [DATA_W-1:0]  head_v [NUM_CH];
    logic [1:0]         cfg_v  [NUM_CH];

    dma_cmpl_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CH  (NUM_CH),
        .VIEW_SEL(VIEW_SEL)
    ) decode_i (
        .addr(bus_addr),
        .sel (sel),
        .chan(chan)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = (chan == CH_W'(g));

        dma_cmpl_chan chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ptr  (bus_wr && hit && sel == RG_PTR),
            .wr_abort(bus_wr && hit && sel == RG_ABORT),
            .wr_cfg  (bus_wr && hit && sel == RG_CFG),
            .wdata   (bus_wdata),
            .pop     (bus_rd && hit && sel == RG_RES),
            .ev_done (ev_done[g]),
            .ev_fault(ev_fault[g]),
            .active  (chan_active[g]),
            .ptr     (ptr_v[g]),
            .cfg     (cfg_v[g]),
            .head    (head_v[g]),
            .pending (pending[g])
        );

        assign ien[g] = cfg_v[g][0];
    end

    dma_cmpl_irq #(.NUM_CH(NUM_CH)) irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pending(pending),
        .ien    (ien),
        .summary(summary),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                RG_PTR:  bus_rdata = ptr_v[chan];
                RG_RES:  bus_rdata = head_v[chan];
                RG_STAT: bus_rdata = {30'd0, pending[chan], chan_active[chan]};
                RG_CFG:  bus_rdata = {30'd0, cfg_v[chan]};
                RG_SUM:  bus_rdata = 32'(summary);
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_summary_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == RG_SUM) |-> (bus_rdata == 32'(pending)));

    assert_offview_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == RG_NONE) |-> (bus_rdata == 32'd0));
endmodule

// File: tb/dma_cmpl_unit_tb.sv
module dma_cmpl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] ev_done = '0;
    logic [15:0] ev_fault = '0;
    logic [15:0] chan_active;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_cmpl_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .ev_done    (ev_done),
        .ev_fault   (ev_fault),
        .chan_active(chan_active),
        .irq        (irq)
    );

    function automatic logic [15:0] a_ptr(int ch);  return 16'(32'h000 + 4*ch); endfunction
    function automatic logic [15:0] a_res(int ch);  return 16'(32'h040 + 4*ch); endfunction
    function automatic logic [15:0] a_abt(int ch);  return 16'(32'h080 + 4*ch); endfunction
    function automatic logic [15:0] a_stat(int ch); return 16'(32'h200 + 4*ch); endfunction
    function automatic logic [15:0] a_cfg(int ch);  return 16'(32'h300 + 4*ch); endfunction
    localparam logic [15:0] A_SUM = 16'h0380;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse(int ch, bit fault);
        @(negedge clk);
        if (fault) ev_fault[ch] = 1'b1; else ev_done[ch] = 1'b1;
        @(negedge clk);
        ev_fault = '0; ev_done = '0;
    endtask

    task automatic t_reset;
        chk("R12 irq", 32'(irq), 0);
        chk("R12 active", 32'(chan_active), 0);
        rd_chk("R12 summary", A_SUM, 0);
        rd_chk("R12 result", a_res(0), 0);
        rd_chk("R12 ptr", a_ptr(15), 0);
    endtask

    task automatic t_start_done;
        wr(a_ptr(3), 32'h0000_1234);
        rd_chk("R1 ptr", a_ptr(3), 32'h0000_1234);
        rd_chk("R1 status", a_stat(3), 32'd1);
        pulse(3, 0);
        rd_chk("R2 status", a_stat(3), 32'd2);
        rd_chk("R7 summary", A_SUM, 32'h0000_0008);
        rd_chk("R2 result", a_res(3), 32'h8000_0002);
        rd_chk("R6 status", a_stat(3), 32'd0);
        rd_chk("R6 empty", a_res(3), 32'd0);
        rd_chk("R7 summary clear", A_SUM, 32'd0);
    endtask

    task automatic t_fault;
        wr(a_ptr(5), 32'h55);
        @(negedge clk);
        ev_fault[5] = 1'b1; ev_done[5] = 1'b1;
        @(negedge clk);
        ev_fault = '0; ev_done = '0;
        rd_chk("R3 result", a_res(5), 32'h8000_0008);
    endtask

    task automatic t_abort;
        wr(a_cfg(2), 32'd2);
        wr(a_ptr(2), 32'h20);
        wr(a_abt(2), 32'hDEAD);
        rd_chk("R4 status report", a_stat(2), 32'd2);
        rd_chk("R4 result", a_res(2), 32'h8000_0004);
        wr(a_cfg(2), 32'd0);
        wr(a_ptr(2), 32'h24);
        wr(a_abt(2), 32'd0);
        rd_chk("R4 silent status", a_stat(2), 32'd0);
        rd_chk("R4 silent summary", A_SUM, 32'd0);
    endtask

    task automatic t_busy_ptr;
        wr(a_ptr(7), 32'hA0);
        wr(a_ptr(7), 32'hB0);
        rd_chk("R5 ptr kept", a_ptr(7), 32'hA0);
        rd_chk("R5 status", a_stat(7), 32'd3);
        rd_chk("R5 result", a_res(7), 32'h8000_0008);
        pulse(7, 0);
        rd_chk("R5 list continues", a_res(7), 32'h8000_0002);
    endtask

    task automatic t_queue;
        for (int k = 0; k < 3; k++) begin
            wr(a_ptr(9), 32'(k));
            pulse(9, 0);
        end
        rd_chk("R9 first", a_res(9), 32'h8000_0002);
        rd_chk("R9 second marked", a_res(9), 32'h8000_000A);
        rd_chk("R9 dropped", a_res(9), 32'd0);
    endtask

    task automatic t_irq;
        wr(a_ptr(4), 32'h40);
        pulse(4, 0);
        chk("R8 masked", 32'(irq), 0);
        rd_chk("R7 pending", A_SUM, 32'h0000_0010);
        wr(a_cfg(4), 32'd1);
        chk("R8 enabled", 32'(irq), 1);
        rd_chk("R8 pop", a_res(4), 32'h8000_0002);
        chk("R8 cleared", 32'(irq), 0);
    endtask

    task automatic t_idle;
        pulse(6, 0);
        pulse(6, 1);
        rd_chk("R10 events", a_stat(6), 32'd0);
        wr(a_cfg(6), 32'd2);
        wr(a_abt(6), 32'd1);
        rd_chk("R10 abort", a_stat(6), 32'd0);
        rd_chk("R10 summary", A_SUM, 32'd0);
    endtask

    task automatic t_view;
        wr(16'h0800 | a_ptr(1), 32'h77);
        rd_chk("R11 write ignored", a_stat(1), 32'd0);
        wr(a_ptr(1), 32'h11);
        pulse(1, 0);
        rd_chk("R11 read zero", 16'h0800 | a_res(1), 32'd0);
        rd_chk("R11 no pop", a_res(1), 32'h8000_0002);
    endtask

    task automatic t_collide;
        wr(a_ptr(8), 32'h80);
        @(negedge clk);
        bus_addr = a_cfg(8); bus_wdata = 32'd0; bus_wr = 1'b1; ev_done[8] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_done = '0;
        rd_chk("R13 pulse lost", a_stat(8), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_done();
        t_fault();
        t_abort();
        t_busy_ptr();
        t_queue();
        t_irq();
        t_idle();
        t_view();
        t_collide();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule